// File: doc/BRIEF.md
# Content-Addressable Match Unit

This block is a small content-addressable store with a configurable number of entries and entry width (default four entries of four bits). One data bus serves two purposes. On a write it is the value placed into the entry that the entry index selects. On a search it is the key, and the key is compared against every stored entry in the same cycle.

Each search returns three results. A flag is set when exactly one entry holds the key. A second flag is set when two or more entries hold it. An index output gives the position of the entry that matched. The results are registered and appear one clock after the request.

All entries hold zero after reset and take part in matching from that point on. A search for zero before any write therefore matches every entry. The block is meant to sit in front of a lookup structure. That structure decides what to do on a miss or on a multiple match.

Top module: `cam_match_unit`

## Requirements
- R1: While rst_ni is low, every entry is cleared to zero and single_match_o, multiple_match_o and match_addr_o are driven to 0.
- R2: A cycle with enable_i low does not change any entry, even when write_enable_i is high. The result registered for that cycle is single_match_o=0, multiple_match_o=0 and match_addr_o=0.
- R3: When enable_i=1 and write_enable_i=1, data_i is stored in entry addr_i and the other entries keep their values. The result registered for that cycle reports no match: both flags 0 and match_addr_o=0.
- R4: When a search (enable_i=1, write_enable_i=0) finds exactly one entry equal to data_i, the result is single_match_o=1, multiple_match_o=0 and match_addr_o set to that entry's index.
- R5: When two or more entries equal the key, the result is multiple_match_o=1, single_match_o=0 and match_addr_o set to the lowest matching index.
- R6: When no entry equals the key, the result is both flags 0 and match_addr_o=0.
- R7: A search for zero right after reset, with no write yet, reports multiple_match_o=1 and match_addr_o=0.
- R8: A search in the cycle directly after a write sees the newly written value.
- R9: The result of a request sampled at a rising clock edge appears on the outputs just after that edge. It holds until the next edge.
- R10: single_match_o and multiple_match_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Request valid |
| write_enable_i | input | 1 | 1 = write, 0 = search (when enable_i=1) |
| addr_i | input | $clog2(N_ENTRIES) | Entry index for writes |
| data_i | input | DATA_W | Write value or search key |
| single_match_o | output | 1 | Exactly one entry matched |
| multiple_match_o | output | 1 | Two or more entries matched |
| match_addr_o | output | $clog2(N_ENTRIES) | Index of the (lowest) matching entry |

## Verification
The hardest cases to reach are the ones that depend on the exact contents of the store. Examples are a multiple match whose lowest hit is not entry 0, a single hit on the last entry, and a search placed in the very cycle after a write of the same key. The stimulus table builds these contents on purpose. It first fills two entries with the same value to get a duplicate, then overwrites entries one by one. Zero, left in the untouched entries, then survives in only the last entry. The table also puts a write followed at once by a search of the same value, with no idle cycle between them. Directed tests add a disabled write that must leave the store unchanged, a check of the outputs one cycle early to confirm the latency, and a reset in the middle of the run that must bring back the all-zero, all-match state.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_SEARCH = 2'd2
  } cam_op_e;

  function automatic cam_op_e decode_op(input logic en, input logic we);
    if (!en)    return OP_IDLE;
    else if (we) return OP_WRITE;
    else        return OP_SEARCH;
  endfunction

endpackage

// File: rtl/cam_entry_store.sv
module cam_entry_store #(
  parameter int N_ENTRIES = 4,
  parameter int DATA_W    = 4,
  localparam int AW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [AW-1:0]                   wr_addr_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  output logic [N_ENTRIES-1:0][DATA_W-1:0] entries_o
);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (wr_addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  entries_o[g] <= '0;
      else if (sel) entries_o[g] <= wr_data_i;
    end
  end

endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
  parameter int N_ENTRIES = 4,
  parameter int DATA_W    = 4
) (
  input  logic [DATA_W-1:0]                key_i,
  input  logic [N_ENTRIES-1:0][DATA_W-1:0] entries_i,
  output logic [N_ENTRIES-1:0]             hit_o
);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = (entries_i[g] == key_i);
  end

endmodule

// File: rtl/cam_match_encode.sv
module cam_match_encode #(
  parameter int N_ENTRIES = 4,
  localparam int AW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0] hit_i,
  output logic                 single_o,
  output logic                 multi_o,
  output logic [AW-1:0]        addr_o
);

  logic [N_ENTRIES-1:0] rest;
  logic                 any_hit;

  // clearing the lowest set bit leaves something only if >= 2 hits
  assign rest     = hit_i & (hit_i - N_ENTRIES'(1));
  assign any_hit  = |hit_i;
  assign multi_o  = |rest;
  assign single_o = any_hit && !multi_o;

  always_comb begin
    addr_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) addr_o = AW'(i);
    end
  end

endmodule

// File: rtl/cam_match_unit.sv
module cam_match_unit
  import cam_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int DATA_W    = 4,
  localparam int AW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              write_enable_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              single_match_o,
  output logic              multiple_match_o,
  output logic [AW-1:0]     match_addr_o
);

  cam_op_e                          op;
  logic [N_ENTRIES-1:0][DATA_W-1:0] entries;
  logic [N_ENTRIES-1:0]             hit;
  logic                             single_c, multi_c;
  logic [AW-1:0]                    addr_c;

  assign op = decode_op(enable_i, write_enable_i);

  cam_entry_store #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (op == OP_WRITE),
    .wr_addr_i (addr_i),
    .wr_data_i (data_i),
    .entries_o (entries)
  );

  cam_compare #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W)) u_cmp (
    .key_i     (data_i),
    .entries_i (entries),
    .hit_o     (hit)
  );

  cam_match_encode #(.N_ENTRIES(N_ENTRIES)) u_enc (
    .hit_i    (hit),
    .single_o (single_c),
    .multi_o  (multi_c),
    .addr_o   (addr_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_match_o   <= 1'b0;
      multiple_match_o <= 1'b0;
      match_addr_o     <= '0;
    end else if (op == OP_SEARCH) begin
      single_match_o   <= single_c;
      multiple_match_o <= multi_c;
      match_addr_o     <= addr_c;
    end else begin
      single_match_o   <= 1'b0;
      multiple_match_o <= 1'b0;
      match_addr_o     <= '0;
    end
  end

endmodule

// File: rtl/cam_match_unit_chk.sv
module cam_match_unit_chk #(
  parameter int N_ENTRIES = 4,
  parameter int DATA_W    = 4,
  localparam int AW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              write_enable_i,
  input logic [AW-1:0]     addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              single_match_o,
  input logic              multiple_match_o,
  input logic [AW-1:0]     match_addr_o
);

  assert_flags_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(single_match_o && multiple_match_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!single_match_o && !multiple_match_o && match_addr_o == '0));

  assert_write_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && write_enable_i) |=> (!single_match_o && !multiple_match_o && match_addr_o == '0));

  assert_miss_addr_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_match_o && !multiple_match_o) |-> (match_addr_o == '0));

  assert_write_then_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !write_enable_i && $past(enable_i && write_enable_i)
     && data_i == $past(data_i)) |=> (single_match_o || multiple_match_o));

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!single_match_o && !multiple_match_o && match_addr_o == '0));

endmodule

bind cam_match_unit cam_match_unit_chk #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .enable_i         (enable_i),
  .write_enable_i   (write_enable_i),
  .addr_i           (addr_i),
  .data_i           (data_i),
  .single_match_o   (single_match_o),
  .multiple_match_o (multiple_match_o),
  .match_addr_o     (match_addr_o)
);

// File: tb/sim_cam_match_unit.sv
module sim_cam_match_unit;

  localparam int CLK_P = 10;
  localparam int NV    = 21;
  localparam int WDOG  = 5000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       write_enable_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [3:0] data_i = '0;
  logic       single_match_o, multiple_match_o;
  logic [1:0] match_addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cam_match_unit u0 (
    .clk_i, .rst_ni, .enable_i, .write_enable_i, .addr_i, .data_i,
    .single_match_o, .multiple_match_o, .match_addr_o
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  // {en, we, addr[1:0], data[3:0], exp_single, exp_multi, exp_addr[1:0], req[3:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0,1'b0,2'd0,4'd0,  1'b0,1'b0,2'd0,4'd2},   // R2 idle
    {1'b1,1'b0,2'd0,4'd0,  1'b0,1'b1,2'd0,4'd7},   // R7 all-zero multi
    {1'b1,1'b0,2'd0,4'd1,  1'b0,1'b0,2'd0,4'd6},   // R6 miss
    {1'b1,1'b1,2'd0,4'd4,  1'b0,1'b0,2'd0,4'd3},   // R3 write e0=4
    {1'b1,1'b0,2'd0,4'd4,  1'b1,1'b0,2'd0,4'd4},   // R4 hit e0
    {1'b1,1'b0,2'd0,4'd5,  1'b0,1'b0,2'd0,4'd6},   // R6 miss
    {1'b1,1'b1,2'd1,4'd5,  1'b0,1'b0,2'd0,4'd3},   // R3 write e1=5
    {1'b1,1'b1,2'd2,4'd5,  1'b0,1'b0,2'd0,4'd3},   // R3 write e2=5
    {1'b1,1'b0,2'd1,4'd5,  1'b0,1'b1,2'd1,4'd5},   // R5 multi lowest=1
    {1'b1,1'b1,2'd0,4'd7,  1'b0,1'b0,2'd0,4'd3},   // R3 write e0=7
    {1'b1,1'b0,2'd0,4'd7,  1'b1,1'b0,2'd0,4'd8},   // R8 back-to-back hit
    {1'b1,1'b0,2'd0,4'd0,  1'b1,1'b0,2'd3,4'd4},   // R4 hit e3 (R3 others kept)
    {1'b0,1'b1,2'd3,4'd9,  1'b0,1'b0,2'd0,4'd2},   // R2 disabled write
    {1'b1,1'b0,2'd0,4'd0,  1'b1,1'b0,2'd3,4'd2},   // R2 e3 still 0
    {1'b1,1'b0,2'd0,4'd9,  1'b0,1'b0,2'd0,4'd2},   // R2 9 never stored
    {1'b1,1'b1,2'd3,4'd5,  1'b0,1'b0,2'd0,4'd3},   // R3 write e3=5
    {1'b1,1'b0,2'd0,4'd5,  1'b0,1'b1,2'd1,4'd5},   // R5 three hits
    {1'b1,1'b1,2'd1,4'd12, 1'b0,1'b0,2'd0,4'd3},   // R3 write e1=12
    {1'b1,1'b1,2'd2,4'd12, 1'b0,1'b0,2'd0,4'd3},   // R3 write e2=12
    {1'b1,1'b0,2'd0,4'd12, 1'b0,1'b1,2'd1,4'd5},   // R5 multi lowest=1
    {1'b1,1'b0,2'd0,4'd5,  1'b1,1'b0,2'd3,4'd4}    // R4 hit e3
  };

  task automatic check(input int req, input logic s, input logic m, input logic [1:0] a);
    checks++;
    if (single_match_o !== s || multiple_match_o !== m || match_addr_o !== a) begin
      fails++;
      $display("FAIL R%0d: got single=%b multi=%b addr=%0d, expected single=%b multi=%b addr=%0d",
               req, single_match_o, multiple_match_o, match_addr_o, s, m, a);
    end
    if (single_match_o && multiple_match_o) begin
      fails++;
      $display("FAIL R10: got both flags high, expected at most one");
    end
  endtask

  task automatic apply(input logic en, input logic we, input logic [1:0] a, input logic [3:0] d);
    @(negedge clk_i);
    enable_i = en; write_enable_i = we; addr_i = a; data_i = d;
  endtask

  initial begin
    // R1: outputs cleared while in reset
    #(CLK_P*2 + 1);
    check(1, 1'b0, 1'b0, 2'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15], VEC[i][14], VEC[i][13:12], VEC[i][11:8]);
      @(negedge clk_i);
      check(int'(VEC[i][3:0]), VEC[i][7], VEC[i][6], VEC[i][5:4]);
    end

    // R9: new request not visible before the edge, visible right after
    enable_i = 1'b1; write_enable_i = 1'b0; data_i = 4'd7;
    @(posedge clk_i);
    #1;
    check(9, 1'b1, 1'b0, 2'd0);
    apply(1'b1, 1'b0, 2'd0, 4'd12);
    #(CLK_P/2 - 2);
    check(9, 1'b1, 1'b0, 2'd0);
    @(posedge clk_i);
    #1;
    check(9, 1'b0, 1'b1, 2'd1);

    // R1: reset mid-run clears entries; zero matches all again
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(1, 1'b0, 1'b0, 2'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(1'b1, 1'b0, 2'd0, 4'd0);
    @(negedge clk_i);
    check(1, 1'b0, 1'b1, 2'd0);
    apply(1'b1, 1'b0, 2'd0, 4'd12);
    @(negedge clk_i);
    check(1, 1'b0, 1'b0, 2'd0);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WDOG) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cyc);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule